// File: doc/BRIEF.md
# Deferred Condition Flag Resolver

This unit works out the condition flags of a 32-bit integer datapath some time after the operation that set them. The execute stage does not produce flags. It saves three things: an operation class, the result word, and the second operand. The flags are built from these only when some later step needs them. The first operand is not kept. The resolver rebuilds it from the result and the saved operand, then derives negative (N), zero (Z), overflow (V), carry (C) and extend (X).

A request gives the operation code, the saved result, the saved operand and the current flag word. One clock later the registered flag word shows the resolved flags. A one-cycle pulse on `flags_raw_o` says the flags are now in raw form. The caller can then store `raw` as the new operation class and put the flag word back as the result word.

- **Compare operations** work at byte or halfword width.
- **Extended add and subtract** keep Z sticky across a chain of operations.
- **Undefined operation codes** are reported and do not disturb the flag register.

Top module: `lazy_flag_unit`

## Requirements
- R1: Flag word layout is C bit 0, V bit 1, Z bit 2, N bit 3, X bit 4. With op code 0 (raw), the low five bits of the result word become the flag word unchanged.
- R2: With op code 1 (logic), Z is set for a zero result and N copies result bit 31. V and C are cleared, and X keeps its previous value.
- R3: With op code 2 (add), the first operand is rebuilt as result minus operand. C is set when the result is unsigned-less than the operand. V is set when the rebuilt operand and the operand share a sign and the result's sign differs from it.
- R4: With op code 3 (subtract), the minuend is rebuilt as result plus operand. C is set when the minuend is unsigned-less than the operand. V is set when the minuend differs in sign from both the operand and the result.
- R5: Op codes 4 and 5 (byte and halfword compare) apply the subtract rule to the low 8 or 16 bits only. N, Z, V and C come from bit 7 or bit 15, and X keeps its previous value.
- R6: With op code 6 (add-extended), the first operand is rebuilt as result minus operand minus one. C is set when the result is unsigned-less-or-equal to the operand, and V follows the add rule.
- R7: With op code 7 (subtract-extended), the minuend is rebuilt as result plus operand plus one. C is set when the minuend is unsigned-less-or-equal to the operand, and V follows the subtract rule.
- R8: With op code 8 (shift), N and Z come from the result, C is set when the saved operand is nonzero, and V is cleared.
- R9: For op codes 6 and 7, the new Z is the computed Z ANDed with the previous Z. A zero result never sets Z.
- R10: For op codes 2, 3, 6, 7 and 8, X equals the new C.
- R11: An op code from 9 to 15 pulses `op_error_o` for one cycle. It raises no `flags_raw_o` and leaves the flag register unchanged.
- R12: After reset the flag word is 0 and both pulses are low. A defined request updates the flag word and pulses `flags_raw_o` on the following cycle. Without a request, the flag word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Resolve request |
| req_op_i | input | 4 | Saved operation class |
| req_result_i | input | 32 | Saved result word |
| req_src_i | input | 32 | Saved second operand |
| req_flags_i | input | 5 | Current flag word |
| flags_o | output | 5 | Registered resolved flag word |
| flags_raw_o | output | 1 | One-cycle pulse: flags now in raw form |
| op_error_o | output | 1 | One-cycle pulse: undefined op code |

## Verification
Several properties are checked on every clock cycle:
- Logic requests never leave V or C set, and never set N and Z together.
- Raw requests copy the word through.
- An extended operation with Z clear keeps Z clear.
- An error pulse never coincides with a raw pulse, and never moves the flag word.

Only the bench's scenarios can show that the rebuilt operands give the right carry and overflow. These scenarios cover:
- wrap-around at zero and at the sign boundary;
- compares whose upper bits hold unrelated data;
- the or-equal carry rules of the extended forms;
- X following or ignoring C by operation class.

// File: rtl/lazy_flag_pkg.sv
package lazy_flag_pkg;

   localparam int FLAG_W = 5;
   localparam int OP_W   = 4;

   typedef enum logic [OP_W-1:0] {
      OP_RAW   = 4'd0,
      OP_LOGIC = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_CMP8  = 4'd4,
      OP_CMP16 = 4'd5,
      OP_ADDX  = 4'd6,
      OP_SUBX  = 4'd7,
      OP_SHIFT = 4'd8
   } lf_op_e;

   // packed: x is bit 4 down to c at bit 0
   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } lf_flags_t;

   function automatic logic lf_op_defined(logic [OP_W-1:0] code);
      return code <= OP_SHIFT;
   endfunction

   function automatic logic lf_op_sets_x(logic [OP_W-1:0] code);
      return (code == OP_ADD) || (code == OP_SUB) || (code == OP_ADDX) ||
             (code == OP_SUBX) || (code == OP_SHIFT);
   endfunction

endpackage

// File: rtl/lf_sign_zero.sv
module lf_sign_zero #(
   parameter int W = 32
) (
   input  logic [W-1:0] val_i,
   output logic         neg_o,
   output logic         zero_o
);
   if (W < 2) begin : g_bad_w
      $error("lf_sign_zero: W must be at least 2");
   end

   assign zero_o = (val_i == '0);
   assign neg_o  = val_i[W-1];

endmodule

// File: rtl/lf_rebuild.sv
module lf_rebuild
   import lazy_flag_pkg::*;
#(
   parameter int W = 32
) (
   input  lf_op_e       mode_i,
   input  logic [W-1:0] res_i,
   input  logic [W-1:0] src_i,
   output logic         c_o,
   output logic         v_o,
   output logic [W-1:0] lost_o
);
   localparam int        MSB = W - 1;
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] add_base, addx_base, sub_base, subx_base;
   logic         add_ovf, addx_ovf, sub_ovf, subx_ovf;

   // rebuilt first operand for each class
   assign add_base  = res_i - src_i;
   assign addx_base = res_i - src_i - ONE;
   assign sub_base  = res_i + src_i;
   assign subx_base = res_i + src_i + ONE;

   assign add_ovf  = ((src_i ^ res_i) & ~(add_base  ^ src_i)) >> MSB != '0;
   assign addx_ovf = ((src_i ^ res_i) & ~(addx_base ^ src_i)) >> MSB != '0;
   assign sub_ovf  = ((sub_base  ^ res_i) & (sub_base  ^ src_i)) >> MSB != '0;
   assign subx_ovf = ((subx_base ^ res_i) & (subx_base ^ src_i)) >> MSB != '0;

   always_comb begin
      c_o    = 1'b0;
      v_o    = 1'b0;
      lost_o = '0;
      unique case (mode_i)
         OP_ADD: begin
            c_o    = res_i < src_i;
            v_o    = add_ovf;
            lost_o = add_base;
         end
         OP_ADDX: begin
            c_o    = res_i <= src_i;
            v_o    = addx_ovf;
            lost_o = addx_base;
         end
         OP_SUB, OP_CMP8, OP_CMP16: begin
            c_o    = sub_base < src_i;
            v_o    = sub_ovf;
            lost_o = sub_base;
         end
         OP_SUBX: begin
            c_o    = subx_base <= src_i;
            v_o    = subx_ovf;
            lost_o = subx_base;
         end
         default: begin
            c_o    = 1'b0;
            v_o    = 1'b0;
            lost_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/lf_resolve.sv
module lf_resolve
   import lazy_flag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic [DATA_W-1:0] src_i,
   input  lf_flags_t         prev_i,
   output lf_flags_t         next_o,
   output logic              defined_o
);
   localparam int LANES = 3;
   localparam int FULL  = LANES - 1;

   if (!(BYTE_W < HALF_W && HALF_W < DATA_W)) begin : g_bad_lanes
      $error("lf_resolve: lane widths must grow strictly up to DATA_W");
   end
   if (DATA_W < FLAG_W) begin : g_bad_data
      $error("lf_resolve: DATA_W narrower than the flag word");
   end

   logic [LANES-1:0] lane_c, lane_v, lane_n, lane_z;
   lf_op_e           op_enum;

   assign op_enum = lf_op_e'(op_i);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : (g == 1) ? HALF_W : DATA_W;
      lf_op_e        mode;
      logic [LW-1:0] lost;

      assign mode = (g == FULL) ? op_enum : OP_SUB;

      lf_rebuild #(.W(LW)) i_rebuild (
         .mode_i (mode),
         .res_i  (res_i[LW-1:0]),
         .src_i  (src_i[LW-1:0]),
         .c_o    (lane_c[g]),
         .v_o    (lane_v[g]),
         .lost_o (lost)
      );

      lf_sign_zero #(.W(LW)) i_nz (
         .val_i  (res_i[LW-1:0]),
         .neg_o  (lane_n[g]),
         .zero_o (lane_z[g])
      );
   end

   lf_flags_t calc;

   always_comb begin
      calc   = prev_i;
      calc.n = lane_n[FULL];
      calc.z = lane_z[FULL];
      calc.v = 1'b0;
      calc.c = 1'b0;
      unique case (op_enum)
         OP_RAW: calc = lf_flags_t'(res_i[FLAG_W-1:0]);
         OP_LOGIC: ;
         OP_ADD, OP_SUB, OP_ADDX, OP_SUBX: begin
            calc.c = lane_c[FULL];
            calc.v = lane_v[FULL];
         end
         OP_CMP8: begin
            calc.n = lane_n[0];
            calc.z = lane_z[0];
            calc.c = lane_c[0];
            calc.v = lane_v[0];
         end
         OP_CMP16: begin
            calc.n = lane_n[1];
            calc.z = lane_z[1];
            calc.c = lane_c[1];
            calc.v = lane_v[1];
         end
         OP_SHIFT: calc.c = |src_i;
         default: calc = prev_i;
      endcase
      // extended forms: a nonzero result may clear Z, never set it
      if (op_enum == OP_ADDX || op_enum == OP_SUBX) begin
         calc.z = calc.z & prev_i.z;
      end
      if (lf_op_sets_x(op_i)) begin
         calc.x = calc.c;
      end
   end

   assign next_o    = calc;
   assign defined_o = lf_op_defined(op_i);

endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit
   import lazy_flag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [3:0]        req_op_i,
   input  logic [DATA_W-1:0] req_result_i,
   input  logic [DATA_W-1:0] req_src_i,
   input  logic [4:0]        req_flags_i,
   output logic [4:0]        flags_o,
   output logic              flags_raw_o,
   output logic              op_error_o
);
   if (OP_W != 4 || FLAG_W != 5) begin : g_bad_pkg
      $error("lazy_flag_unit: port widths disagree with package");
   end

   lf_flags_t next_flags, flags_q;
   logic      defined;
   logic      raw_q, err_q;

   lf_resolve #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .HALF_W (HALF_W)
   ) i_resolve (
      .op_i      (req_op_i),
      .res_i     (req_result_i),
      .src_i     (req_src_i),
      .prev_i    (lf_flags_t'(req_flags_i)),
      .next_o    (next_flags),
      .defined_o (defined)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
         raw_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         raw_q <= req_valid_i & defined;
         err_q <= req_valid_i & ~defined;
         if (req_valid_i && defined) begin
            flags_q <= next_flags;
         end
      end
   end

   assign flags_o     = flags_q;
   assign flags_raw_o = raw_q;
   assign op_error_o  = err_q;

   // R1: raw request copies the low word bits into the register
   a_r1_raw_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op_i == OP_RAW) |=> (flags_o == $past(req_result_i[4:0])));

   // R2: logic leaves V and C clear and never sets N with Z
   a_r2_logic_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op_i == OP_LOGIC) |=>
         (!flags_o[1] && !flags_o[0] && !(flags_o[3] && flags_o[2])));

   // R9: extended op with Z clear keeps Z clear
   a_r9_sticky_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (req_op_i == OP_ADDX || req_op_i == OP_SUBX) && !req_flags_i[2])
         |=> !flags_o[2]);

   // R11: error pulse leaves the flag word untouched
   a_r11_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_error_o |-> $stable(flags_o));

   // R11: error and raw pulses exclusive
   a_r11_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(op_error_o && flags_raw_o));

   // R12: idle cycle holds the flag word and drops both pulses
   a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> ($stable(flags_o) && !flags_raw_o && !op_error_o));

endmodule

// File: tb/test_lazy_flag_unit.sv
`timescale 1ns/1ps
module test_lazy_flag_unit;

   typedef struct {
      logic [4:0] flags;
      logic       raw;
      logic       err;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] res = '0;
   logic [31:0] src = '0;
   logic [4:0]  prev = '0;
   logic [4:0]  flags;
   logic        raw, err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [4:0] model_flags = '0;
   exp_t q[$];

   always #4 clk = ~clk;

   lazy_flag_unit i_lazy_flag_unit (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (vld),
      .req_op_i     (op),
      .req_result_i (res),
      .req_src_i    (src),
      .req_flags_i  (prev),
      .flags_o      (flags),
      .flags_raw_o  (raw),
      .op_error_o   (err)
   );

   function automatic logic sg(logic [63:0] x, int w);
      return x[w-1];
   endfunction

   function automatic logic [4:0] ref_flags(int code, logic [31:0] r, logic [31:0] s,
                                            logic [4:0] p);
      logic x, n, z, v, c;
      logic [63:0] m, rr, ss, a;
      int w;
      x = p[4]; n = 0; z = 0; v = 0; c = 0;
      if (code == 0) return r[4:0];
      if (code == 1 || code == 8) begin
         n = r[31];
         z = (r == 0);
         if (code == 8) begin c = (s != 0); x = c; end
         return {x, n, z, v, c};
      end
      w  = (code == 4) ? 8 : (code == 5) ? 16 : 32;
      m  = (64'd1 << w) - 1;
      rr = {32'd0, r} & m;
      ss = {32'd0, s} & m;
      case (code)
         2: begin a = (rr - ss) & m;     c = rr < ss;  end
         6: begin a = (rr - ss - 1) & m; c = rr <= ss; end
         7: begin a = (rr + ss + 1) & m; c = a <= ss;  end
         default: begin a = (rr + ss) & m; c = a < ss; end
      endcase
      if (code == 2 || code == 6)
         v = (sg(a, w) == sg(ss, w)) && (sg(rr, w) != sg(a, w));
      else
         v = (sg(a, w) != sg(ss, w)) && (sg(rr, w) != sg(a, w));
      n = sg(rr, w);
      z = (rr == 0);
      if (code == 6 || code == 7) z = z & p[2];
      if (code == 2 || code == 3 || code == 6 || code == 7) x = c;
      return {x, n, z, v, c};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // driver: apply one request, push what the monitor should see
   task automatic send(int code, logic [31:0] r, logic [31:0] s, logic [4:0] p, string tag);
      exp_t e;
      @(negedge clk);
      vld = 1'b1; op = 4'(code); res = r; src = s; prev = p;
      @(posedge clk);
      #1;
      if (code <= 8) begin
         model_flags = ref_flags(code, r, s, p);
         e.raw = 1'b1; e.err = 1'b0;
      end else begin
         e.raw = 1'b0; e.err = 1'b1;
      end
      e.flags = model_flags;
      e.tag   = tag;
      q.push_back(e);
      vld = 1'b0;
   endtask

   // monitor: compare one item per output pulse, away from the edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, {25'd0, err, raw, flags}, {25'd0, e.err, e.raw, e.flags});
         end else if (raw || err) begin
            check("R12 unexpected pulse", {30'd0, err, raw}, 32'd0);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R12 reset flags", {27'd0, flags}, 32'd0);
      check("R12 reset pulses", {30'd0, err, raw}, 32'd0);
      rst_n = 1'b1;

      send(0, 32'hABCD_0015, 32'h0, 5'h00, "R1 raw pass");
      send(1, 32'h0, 32'h5, 5'h1F, "R2 logic zero keeps X");
      send(1, 32'h8000_0001, 32'h0, 5'h00, "R2 logic negative");
      send(2, 32'h0, 32'h1, 5'h00, "R3 add wrap carry zero");
      send(2, 32'h8000_0000, 32'h1, 5'h00, "R3 add overflow");
      send(3, 32'hFFFF_FFFF, 32'h1, 5'h00, "R4 sub borrow");
      send(3, 32'h7FFF_FFFF, 32'h1, 5'h00, "R4 sub overflow");
      send(4, 32'hABCD_EF7F, 32'hFFFF_FF01, 5'h10, "R5 byte cmp overflow");
      send(4, 32'h1234_5600, 32'h0000_AA00, 5'h00, "R5 byte cmp zero");
      send(5, 32'hDEAD_7FFF, 32'h5555_0001, 5'h00, "R5 half cmp overflow");
      send(6, 32'h5, 32'h5, 5'h00, "R6 addx carry equal");
      send(6, 32'h8000_0000, 32'h0, 5'h00, "R6 addx overflow");
      send(7, 32'hFFFF_FFFF, 32'h0, 5'h04, "R7 subx borrow equal");
      send(7, 32'h7FFF_FFFE, 32'h1, 5'h04, "R7 subx overflow");
      send(6, 32'h0, 32'h7, 5'h04, "R9 addx zero keeps Z");
      send(6, 32'h0, 32'h7, 5'h00, "R9 addx zero no set Z");
      send(7, 32'h0, 32'h3, 5'h00, "R9 subx zero no set Z");
      send(8, 32'h8000_0000, 32'h1, 5'h00, "R8 shift carry out");
      send(8, 32'h0, 32'h0, 5'h1F, "R8 R10 shift no carry clears X");
      send(3, 32'h1, 32'h1, 5'h1F, "R10 sub clears X");
      send(9, 32'h1F, 32'h0, 5'h00, "R11 undefined 9");
      send(15, 32'h0, 32'h0, 5'h1F, "R11 undefined 15");
      repeat (4) @(negedge clk);
      check("R12 idle hold", {27'd0, flags}, {27'd0, model_flags});

      lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r, s;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223; r = lfsr;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223; s = lfsr;
         if (i % 5 == 0) s = r;
         if (i % 7 == 0) r = 32'h0;
         send(i % 9, r, s, 5'(lfsr[12:8]), "R3 R4 R5 R6 R7 R8 R10 sweep");
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule